// File: doc/BRIEF.md
# NAND Factory Bad-Block Scanner

This engine surveys one die of a NAND array at power-up and builds a list of the blocks the factory marked as bad. After a start request it visits every block of the selected die in ascending order. For each block it asks an external page sequencer for a read of that block's first page. The sequencer returns two marker words: the first 32-bit data word and the first 32-bit spare word. The engine judges the block on those two words alone, never on the whole page.

When a block fails the test, its index goes into the next free slot of a bad-block table through a plain write port, and a running count goes up by one. The table has a fixed depth. A bad block found after the table is full is still counted but is not written, and a sticky overflow flag records that the list is incomplete. The engine does not take the sequencer's ECC verdict as an input, because the factory marker is defined by the raw word values only. A one-cycle done pulse closes the scan. The count and the flag then stay readable until the next scan begins.

Top module: `nand_badblk_scan`

## Requirements
- R1: A `start` seen while idle latches `die_idx`, clears `bad_count` and `overflow`, and raises `busy` on the next cycle. A `start` seen while busy has no effect on the scan in progress: its die, its addresses and its result are unchanged.
- R2: A scan issues exactly `PLANES_PER_DIE*BLKS_PER_PLANE` reads, one for each block index, in ascending order starting at 0.
- R3: The read for block b on die d carries page address (b + PLANES_PER_DIE*BLKS_PER_PLANE*d)*PAGES_PER_BLK, and that address holds steady while the request is pending.
- R4: `rd_req` stays high until the cycle in which `rd_ack` is sampled, then drops for at least one cycle before the next request.
- R5: A block is bad exactly when `rd_data_w0` differs from all-ones or `rd_spare_w0` differs from all-ones, as sampled with `rd_ack`. A change of one bit in either word is enough.
- R6: The indices of bad blocks are written to the table in ascending block order at consecutive addresses starting at 0, with `tbl_wdata` equal to the block index and one write for each bad block.
- R7: At the end of a scan, `bad_count` equals the number of bad blocks on the die, including any that did not fit in the table.
- R8: Once `TBL_DEPTH` entries have been written, later bad blocks cause no write and set `overflow`, which stays set until the next accepted start. If exactly `TBL_DEPTH` blocks are bad, `overflow` stays clear.
- R9: `done` is high for exactly one cycle, two cycles after the acknowledge of the last block is sampled. `busy` is low in the cycle after `done`.
- R10: While idle, `bad_count` and `overflow` hold their values until an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan (taken only while idle) |
| die_idx | input | DIE_W | Die to scan, sampled with an accepted start |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| rd_req | output | 1 | Page read request to the sequencer |
| rd_page_addr | output | PAGE_ADDR_W | Page address of the request |
| rd_ack | input | 1 | Read complete; marker words valid this cycle |
| rd_data_w0 | input | MARK_W | First data word of the page |
| rd_spare_w0 | input | MARK_W | First spare word of the page |
| tbl_we | output | 1 | Table write strobe |
| tbl_addr | output | TBL_AW | Table write address |
| tbl_wdata | output | BLK_W | Bad block index |
| bad_count | output | CNT_W | Number of bad blocks found |
| overflow | output | 1 | Sticky: table was full when a bad block was found |

## Verification
The assertions check the cycle-level rules on every cycle. These are the request hold and the gap after each acknowledge, the steady page address, a count that moves by exactly one with each table write, no write past the table depth, an overflow that rises only when the table is full and never falls during a scan, a single-cycle done, and a count and flag that stay frozen while idle. Only the bench scenarios can show that the block order and page addresses are correct for a given die, that the written list matches the marker pattern, and that the final count is right. The same holds for the exact-depth and past-depth boundaries and for a start pulse injected in the middle of a scan, which must leave that scan untouched.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_GAP  = 2'd2,
      ST_FIN  = 2'd3
   } scan_state_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/bbs_addr_gen.sv
module bbs_addr_gen #(
   parameter int unsigned BLKS_PER_DIE  = 1024,
   parameter int unsigned PAGES_PER_BLK = 64,
   parameter int unsigned BLK_W         = 10,
   parameter int unsigned DIE_W         = 1,
   parameter int unsigned PAGE_ADDR_W   = 24
) (
   input  logic [BLK_W-1:0]       blk,
   input  logic [DIE_W-1:0]       die,
   output logic [PAGE_ADDR_W-1:0] page
);
   localparam int unsigned AW = PAGE_ADDR_W;

   logic [AW-1:0] blk_ext;
   logic [AW-1:0] die_ext;
   logic [AW-1:0] lin_blk;

   assign blk_ext = AW'(blk);
   assign die_ext = AW'(die);
   assign lin_blk = blk_ext + die_ext * AW'(BLKS_PER_DIE);

   generate
      if (bbs_pkg::is_pow2(PAGES_PER_BLK)) begin : g_shift
         localparam int unsigned SH = $clog2(PAGES_PER_BLK);
         assign page = lin_blk << SH;
      end else begin : g_mult
         assign page = lin_blk * AW'(PAGES_PER_BLK);
      end
   endgenerate
endmodule

// File: rtl/bbs_marker_check.sv
module bbs_marker_check #(
   parameter int unsigned MARK_W = 32
) (
   input  logic [MARK_W-1:0] data_w0,
   input  logic [MARK_W-1:0] spare_w0,
   output logic              is_bad
);
   logic data_erased;
   logic spare_erased;

   assign data_erased  = &data_w0;
   assign spare_erased = &spare_w0;
   assign is_bad       = !(data_erased && spare_erased);
endmodule

// File: rtl/bbs_table_writer.sv
module bbs_table_writer #(
   parameter int unsigned TBL_DEPTH = 1024,
   parameter int unsigned TBL_AW    = 10,
   parameter int unsigned BLK_W     = 10,
   parameter int unsigned CNT_W     = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              rec,
   input  logic              is_bad,
   input  logic [BLK_W-1:0]  blk,
   output logic              tbl_we,
   output logic [TBL_AW-1:0] tbl_addr,
   output logic [BLK_W-1:0]  tbl_wdata,
   output logic [CNT_W-1:0]  count,
   output logic              ovf
);
   localparam logic [CNT_W:0] DEPTH_C = (CNT_W+1)'(TBL_DEPTH);

   logic room;
   logic hit;

   assign room      = {1'b0, count} < DEPTH_C;
   assign hit       = rec && is_bad;
   assign tbl_we    = hit && room;
   assign tbl_addr  = TBL_AW'(count);
   assign tbl_wdata = blk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         ovf   <= 1'b0;
      end else if (clr) begin
         count <= '0;
         ovf   <= 1'b0;
      end else if (hit) begin
         count <= count + CNT_W'(1);
         if (!room) ovf <= 1'b1;
      end
   end
endmodule

// File: rtl/nand_badblk_scan.sv
module nand_badblk_scan #(
   parameter int unsigned PLANES_PER_DIE = 1,
   parameter int unsigned BLKS_PER_PLANE = 1024,
   parameter int unsigned PAGES_PER_BLK  = 64,
   parameter int unsigned NUM_DIES       = 2,
   parameter int unsigned PAGE_ADDR_W    = 24,
   parameter int unsigned TBL_DEPTH      = 1024,
   parameter int unsigned MARK_W         = 32,
   localparam int unsigned BLKS_PER_DIE  = PLANES_PER_DIE * BLKS_PER_PLANE,
   localparam int unsigned BLK_W  = (BLKS_PER_DIE > 1) ? $clog2(BLKS_PER_DIE) : 1,
   localparam int unsigned CNT_W  = $clog2(BLKS_PER_DIE + 1),
   localparam int unsigned DIE_W  = (NUM_DIES > 1) ? $clog2(NUM_DIES) : 1,
   localparam int unsigned TBL_AW = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [DIE_W-1:0]       die_idx,
   output logic                   busy,
   output logic                   done,
   output logic                   rd_req,
   output logic [PAGE_ADDR_W-1:0] rd_page_addr,
   input  logic                   rd_ack,
   input  logic [MARK_W-1:0]      rd_data_w0,
   input  logic [MARK_W-1:0]      rd_spare_w0,
   output logic                   tbl_we,
   output logic [TBL_AW-1:0]      tbl_addr,
   output logic [BLK_W-1:0]       tbl_wdata,
   output logic [CNT_W-1:0]       bad_count,
   output logic                   overflow
);
   import bbs_pkg::*;

   localparam longint unsigned TOTAL_PAGES =
      longint'(NUM_DIES) * longint'(BLKS_PER_DIE) * longint'(PAGES_PER_BLK);
   localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(BLKS_PER_DIE - 1);

   // elaboration-time parameter checks
   generate
      if (PLANES_PER_DIE < 1 || BLKS_PER_PLANE < 1) begin : g_err_geom
         $error("nand_badblk_scan: die must hold at least one block");
      end
      if (PAGES_PER_BLK < 1) begin : g_err_ppb
         $error("nand_badblk_scan: PAGES_PER_BLK must be positive");
      end
      if (NUM_DIES < 1) begin : g_err_dies
         $error("nand_badblk_scan: NUM_DIES must be positive");
      end
      if (TBL_DEPTH < 1) begin : g_err_depth
         $error("nand_badblk_scan: TBL_DEPTH must be positive");
      end
      if (MARK_W < 1) begin : g_err_mark
         $error("nand_badblk_scan: MARK_W must be positive");
      end
      if (PAGE_ADDR_W < BLK_W || PAGE_ADDR_W < DIE_W || PAGE_ADDR_W > 48) begin : g_err_aw
         $error("nand_badblk_scan: PAGE_ADDR_W out of range");
      end else if (TOTAL_PAGES > (64'd1 << PAGE_ADDR_W)) begin : g_err_fit
         $error("nand_badblk_scan: page space exceeds PAGE_ADDR_W");
      end
   endgenerate

   scan_state_e      state_q;
   logic [BLK_W-1:0] blk_q;
   logic [DIE_W-1:0] die_q;
   logic             accept;
   logic             rec;
   logic             blk_bad;

   assign accept = (state_q == ST_IDLE) && start;
   assign rec    = (state_q == ST_REQ) && rd_ack;
   assign busy   = (state_q != ST_IDLE);
   assign done   = (state_q == ST_FIN);
   assign rd_req = (state_q == ST_REQ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         blk_q   <= '0;
         die_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start) begin
               die_q   <= die_idx;
               blk_q   <= '0;
               state_q <= ST_REQ;
            end
            ST_REQ: if (rd_ack) state_q <= ST_GAP;
            ST_GAP: begin
               if (blk_q == LAST_BLK) begin
                  state_q <= ST_FIN;
               end else begin
                  blk_q   <= blk_q + BLK_W'(1);
                  state_q <= ST_REQ;
               end
            end
            ST_FIN: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   bbs_addr_gen #(
      .BLKS_PER_DIE (BLKS_PER_DIE),
      .PAGES_PER_BLK(PAGES_PER_BLK),
      .BLK_W        (BLK_W),
      .DIE_W        (DIE_W),
      .PAGE_ADDR_W  (PAGE_ADDR_W)
   ) u_addr (
      .blk (blk_q),
      .die (die_q),
      .page(rd_page_addr)
   );

   bbs_marker_check #(
      .MARK_W(MARK_W)
   ) u_mark (
      .data_w0 (rd_data_w0),
      .spare_w0(rd_spare_w0),
      .is_bad  (blk_bad)
   );

   bbs_table_writer #(
      .TBL_DEPTH(TBL_DEPTH),
      .TBL_AW   (TBL_AW),
      .BLK_W    (BLK_W),
      .CNT_W    (CNT_W)
   ) u_tbl (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (accept),
      .rec      (rec),
      .is_bad   (blk_bad),
      .blk      (blk_q),
      .tbl_we   (tbl_we),
      .tbl_addr (tbl_addr),
      .tbl_wdata(tbl_wdata),
      .count    (bad_count),
      .ovf      (overflow)
   );
endmodule

// File: rtl/bbs_checker.sv
module bbs_checker #(
   parameter int unsigned CNT_W     = 11,
   parameter int unsigned PAW       = 24,
   parameter int unsigned TBL_DEPTH = 1024
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic             rd_req,
   input logic             rd_ack,
   input logic [PAW-1:0]   rd_page_addr,
   input logic             tbl_we,
   input logic [CNT_W-1:0] bad_count,
   input logic             overflow
);
   assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ack) |=> rd_req);

   assert_req_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_ack) |=> !rd_req);

   assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ack) |=> $stable(rd_page_addr));

   assert_write_counts_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_we |=> (bad_count == $past(bad_count) + CNT_W'(1)));

   assert_write_on_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_we |-> (rd_ack && busy));

   assert_no_write_past_depth_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_we |-> (int'(bad_count) < int'(TBL_DEPTH)));

   assert_overflow_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overflow) |-> (int'($past(bad_count)) >= int'(TBL_DEPTH)));

   assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && overflow) |=> overflow);

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   assert_done_excl_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, rd_req}));

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(bad_count) && $stable(overflow)));
endmodule

bind nand_badblk_scan bbs_checker #(
   .CNT_W    (CNT_W),
   .PAW      (PAGE_ADDR_W),
   .TBL_DEPTH(TBL_DEPTH)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .busy        (busy),
   .done        (done),
   .rd_req      (rd_req),
   .rd_ack      (rd_ack),
   .rd_page_addr(rd_page_addr),
   .tbl_we      (tbl_we),
   .bad_count   (bad_count),
   .overflow    (overflow)
);

// File: tb/nand_badblk_scan_tb.sv
`timescale 1ns/1ps
module nand_badblk_scan_tb;
   localparam int PL    = 2;
   localparam int BPP   = 12;
   localparam int BPD   = PL * BPP;
   localparam int PPB   = 4;
   localparam int ND    = 3;
   localparam int PAW   = 12;
   localparam int DEPTH = 8;
   localparam int BW    = $clog2(BPD);
   localparam int CW    = $clog2(BPD + 1);
   localparam int DW    = $clog2(ND);
   localparam int TAW   = $clog2(DEPTH);

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [DW-1:0]  die_idx = '0;
   logic           busy, done, rd_req, tbl_we, overflow;
   logic [PAW-1:0] rd_page_addr;
   logic           rd_ack = 1'b0;
   logic [31:0]    rd_data_w0 = '1;
   logic [31:0]    rd_spare_w0 = '1;
   logic [TAW-1:0] tbl_addr;
   logic [BW-1:0]  tbl_wdata;
   logic [CW-1:0]  bad_count;

   always #10 clk = ~clk;

   nand_badblk_scan #(
      .PLANES_PER_DIE(PL), .BLKS_PER_PLANE(BPP), .PAGES_PER_BLK(PPB),
      .NUM_DIES(ND), .PAGE_ADDR_W(PAW), .TBL_DEPTH(DEPTH), .MARK_W(32)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .die_idx(die_idx),
      .busy(busy), .done(done), .rd_req(rd_req), .rd_page_addr(rd_page_addr),
      .rd_ack(rd_ack), .rd_data_w0(rd_data_w0), .rd_spare_w0(rd_spare_w0),
      .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
      .bad_count(bad_count), .overflow(overflow)
   );

   int  total = 0;
   int  bad = 0;
   bit  pat_d[BPD];
   bit  pat_s[BPD];
   int  scan_die = 0;
   int  req_idx = 0;
   int  dly = 0;
   int  cap[DEPTH];
   int  cap_n = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_addr(input int b, input int d);
      return (b + BPD * d) * PPB;
   endfunction

   function automatic int exp_count();
      int n = 0;
      for (int b = 0; b < BPD; b++) if (pat_d[b] || pat_s[b]) n++;
      return n;
   endfunction

   function automatic int exp_nth(input int k);
      int n = 0;
      for (int b = 0; b < BPD; b++) begin
         if (pat_d[b] || pat_s[b]) begin
            if (n == k) return b;
            n++;
         end
      end
      return -1;
   endfunction

   // page sequencer model
   initial begin
      forever begin
         @(negedge clk);
         if (rd_ack) begin
            rd_ack = 1'b0;
            rd_data_w0 = '1;
            rd_spare_w0 = '1;
         end else if (rd_req) begin
            if (dly > 0) dly--;
            else begin
               chk(req_idx < BPD, "R2 read count", req_idx, BPD - 1);
               chk(int'(rd_page_addr) == exp_addr(req_idx, scan_die), "R3 page address",
                   int'(rd_page_addr), exp_addr(req_idx, scan_die));
               if (req_idx < BPD) begin
                  rd_data_w0  = pat_d[req_idx] ? ~(32'h1 << ($urandom % 32)) : '1;
                  rd_spare_w0 = pat_s[req_idx] ? ~(32'h1 << ($urandom % 32)) : '1;
               end
               rd_ack = 1'b1;
               req_idx++;
               dly = $urandom % 3;
            end
         end
      end
   end

   // table monitor
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (tbl_we) begin
            chk(int'(tbl_addr) == cap_n, "R6 table address", int'(tbl_addr), cap_n);
            if (cap_n < DEPTH) cap[cap_n] = int'(tbl_wdata);
            cap_n++;
         end
      end
   end

   task automatic run_scan(input int die, input bit intrude);
      int n;
      int cyc;
      int held;
      scan_die = die;
      req_idx = 0;
      cap_n = 0;
      @(negedge clk);
      start = 1'b1;
      die_idx = DW'(die);
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R1 busy after start", int'(busy), 1);
      chk(bad_count == '0 && !overflow, "R1 result cleared", int'(bad_count), 0);
      cyc = 0;
      while (!done && cyc < 5000) begin
         @(negedge clk);
         cyc++;
         if (intrude && cyc == 9) begin
            start = 1'b1;
            die_idx = DW'((die + 1) % ND);
         end else begin
            start = 1'b0;
         end
      end
      start = 1'b0;
      chk(done == 1'b1, "R9 done seen", int'(done), 1);
      n = exp_count();
      chk(req_idx == BPD, "R2 reads issued", req_idx, BPD);
      chk(int'(bad_count) == n, "R7 bad count", int'(bad_count), n);
      chk(overflow == (n > DEPTH), "R8 overflow flag", int'(overflow), int'(n > DEPTH));
      chk(cap_n == ((n > DEPTH) ? DEPTH : n), "R8 writes kept", cap_n, (n > DEPTH) ? DEPTH : n);
      for (int k = 0; k < cap_n && k < DEPTH; k++)
         chk(cap[k] == exp_nth(k), "R6 table entry", cap[k], exp_nth(k));
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, "R9 done one cycle", int'(done) + 2 * int'(busy), 0);
      held = int'(bad_count);
      repeat (6) @(negedge clk);
      chk(int'(bad_count) == held && overflow == (n > DEPTH), "R10 hold while idle",
          int'(bad_count), held);
   endtask

   task automatic set_none();
      for (int b = 0; b < BPD; b++) begin pat_d[b] = 0; pat_s[b] = 0; end
   endtask

   initial begin
      #(20 * 150000);
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5ca11ed));
      repeat (3) @(negedge clk);
      chk(!busy && !done && !rd_req && !tbl_we, "R9 reset outputs", int'(busy), 0);
      chk(bad_count == '0 && !overflow, "R7 reset count", int'(bad_count), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R5: all erased, die 0
      set_none();
      run_scan(0, 1'b0);

      // R3 last die, R5 single-word failures at the edges
      set_none();
      pat_d[0] = 1;
      pat_s[BPD-1] = 1;
      run_scan(ND - 1, 1'b0);

      // R8: exactly the table depth
      set_none();
      for (int b = 0; b < DEPTH; b++) pat_d[b*2+1] = 1;
      run_scan(1, 1'b0);

      // R8: beyond the depth
      set_none();
      for (int b = 0; b < DEPTH + 2; b++) pat_s[b*2] = 1;
      run_scan(0, 1'b0);

      // R1: start while busy ignored
      set_none();
      pat_d[3] = 1; pat_s[7] = 1; pat_d[20] = 1;
      run_scan(1, 1'b1);

      // random patterns
      for (int r = 0; r < 8; r++) begin
         for (int b = 0; b < BPD; b++) begin
            pat_d[b] = ($urandom % 4) == 0;
            pat_s[b] = ($urandom % 6) == 0;
         end
         run_scan($urandom % ND, 1'b0);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule